// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a memory that signals a running embedded program or erase operation by flipping a status bit on every read. A single-cycle `start` sets it going. It then reads the status byte at one fixed address through a request/valid read port, again and again. Each time it compares the toggle bit of a pair of successive reads. When the bit holds still, the operation has finished, and the block pulses `done_ok`. The next read the host issues returns array data again.

Sometimes the bit is still changing between the two reads of a pair. The block then looks at the timeout flag of the newer byte. If the flag is low, the device is still working, and the block starts another pair. If the flag is high, the toggle bit may have stopped at the same moment the flag rose. So the block reads one more pair. If that pair agrees, it reports success. If the bit is still changing, it pulses `done_fail`.

A parameter chooses which status bit serves as the toggle bit. One choice is the device-wide bit at position 6. The other is the per-sector bit at position 2. The timeout flag is always bit 5.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `busy`, `rd_req`, `done_ok` and `done_fail` are all low.
- R2: A `start` pulse while idle makes `busy` and `rd_req` high in the next cycle. `rd_addr` always carries the parameter `STATUS_ADDR`.
- R3: A read completes in a cycle where both `rd_req` and `rd_valid` are high, and `rd_data` is sampled only then. `rd_data` presented while `rd_valid` is low has no effect on the result.
- R4: If the toggle bit is equal in both reads of the first pair, `done_ok` rises in the cycle after the second read completes, after exactly two reads.
- R5: If a pair differs and bit 5 of its second byte is 0, the block begins a new pair and reports nothing.
- R6: If a pair differs and bit 5 of its second byte is 1, exactly two further reads follow. If they agree on the toggle bit, `done_ok` is pulsed.
- R7: If the confirming pair also differs, `done_fail` is pulsed. A failure is never reported without a confirming pair.
- R8: `done_ok` and `done_fail` are single-cycle pulses, never both high at once. `busy` is low in the cycle a result is pulsed and high from the cycle after start until then.
- R9: `start` while `busy` is high is ignored: the running poll continues with an unchanged outcome and read count.
- R10: With `USE_SECTOR_BIT = 0` the toggle bit is bit 6. With `USE_SECTOR_BIT = 1` it is bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a poll (acted on when idle) |
| rd_req | output | 1 | Read request, held until a read completes |
| rd_addr | output | ADDR_W | Fixed status address |
| rd_valid | input | 1 | Read data valid; completes the request |
| rd_data | input | DATA_W | Status byte returned by the memory |
| busy | output | 1 | Poll in progress |
| done_ok | output | 1 | One-cycle pulse: operation finished successfully |
| done_fail | output | 1 | One-cycle pulse: operation failed after timeout |

## Verification
The bench sweeps every combination of toggle values and timeout flags over six scripted status bytes. It varies the read latency, and it drives the inverted toggle bit on the data bus while valid is low. A block that samples without valid, or that skips the confirming pair when the timeout flag is set, would report success or failure from the wrong reads. Such a block would also show a read count that differs from the one the bench computes arithmetically. A second instance taps bit 2 while bit 6 carries a different pattern, so a swapped tap changes the outcome. Some runs repeat `start` in the middle of a poll, so a block that restarts on it would consume extra reads.

// File: rtl/tp_pkg.sv
package tp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_PAIR_A = 3'd1,
      ST_PAIR_B = 3'd2,
      ST_CONF_A = 3'd3,
      ST_CONF_B = 3'd4
   } tp_state_e;
endpackage

// File: rtl/tp_bit_tap.sv
module tp_bit_tap #(
   parameter int DATA_W  = 8,
   parameter int TOG_IDX = 6,
   parameter int TMO_IDX = 5
) (
   input  logic [DATA_W-1:0] data_i,
   output logic              tog_o,
   output logic              tmo_o
);
   logic [DATA_W-1:0] tog_terms;
   logic [DATA_W-1:0] tmo_terms;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign tog_terms[i] = (i == TOG_IDX) ? data_i[i] : 1'b0;
      assign tmo_terms[i] = (i == TMO_IDX) ? data_i[i] : 1'b0;
   end

   assign tog_o = |tog_terms;
   assign tmo_o = |tmo_terms;
endmodule

// File: rtl/tp_pair_latch.sv
module tp_pair_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic bit_i,
   output logic first_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      first_o <= 1'b0;
      else if (load_i) first_o <= bit_i;
   end

   AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(first_o)); // R3
endmodule

// File: rtl/tp_poll_fsm.sv
module tp_poll_fsm
   import tp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic rd_valid_i,
   input  logic tog_i,
   input  logic tmo_i,
   input  logic first_i,
   output logic load_first_o,
   output logic rd_req_o,
   output logic busy_o,
   output logic done_ok_o,
   output logic done_fail_o
);
   tp_state_e st_q, st_d;
   logic      ok_d, fail_d;
   logic      hit;
   logic      differs;

   assign hit     = rd_valid_i && (st_q != ST_IDLE);
   assign differs = first_i ^ tog_i;

   always_comb begin
      st_d   = st_q;
      ok_d   = 1'b0;
      fail_d = 1'b0;
      unique case (st_q)
         ST_IDLE:   if (start_i) st_d = ST_PAIR_A;
         ST_PAIR_A: if (hit) st_d = ST_PAIR_B;
         ST_PAIR_B: if (hit) begin
            if (!differs) begin
               st_d = ST_IDLE;
               ok_d = 1'b1;
            end else if (tmo_i) begin
               st_d = ST_CONF_A;
            end else begin
               st_d = ST_PAIR_A;
            end
         end
         ST_CONF_A: if (hit) st_d = ST_CONF_B;
         ST_CONF_B: if (hit) begin
            st_d   = ST_IDLE;
            ok_d   = !differs;
            fail_d = differs;
         end
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         done_ok_o   <= 1'b0;
         done_fail_o <= 1'b0;
      end else begin
         st_q        <= st_d;
         done_ok_o   <= ok_d;
         done_fail_o <= fail_d;
      end
   end

   assign load_first_o = hit && ((st_q == ST_PAIR_A) || (st_q == ST_CONF_A));
   assign rd_req_o     = (st_q != ST_IDLE);
   assign busy_o       = (st_q != ST_IDLE);

   AST_FAIL_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
      done_fail_o |-> $past(st_q == ST_CONF_B)); // R7
   AST_CONFIRM_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PAIR_B && hit && differs && tmo_i) |=> (st_q == ST_CONF_A)); // R6
   AST_LOOP_ON_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PAIR_B && hit && differs && !tmo_i) |=> (st_q == ST_PAIR_A && !done_ok_o)); // R5
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
   parameter int                DATA_W         = 8,
   parameter int                ADDR_W         = 16,
   parameter logic [ADDR_W-1:0] STATUS_ADDR    = '0,
   parameter bit                USE_SECTOR_BIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done_ok,
   output logic              done_fail
);
   localparam int TMO_IDX = 5;
   localparam int TOG_IDX = USE_SECTOR_BIT ? 2 : 6;

   if (DATA_W < 8) begin : g_bad_width
      $error("toggle_poll_ctrl: DATA_W must be at least 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("toggle_poll_ctrl: ADDR_W must be positive");
   end

   logic tog, tmo, first_bit, load_first;

   tp_bit_tap #(
      .DATA_W (DATA_W),
      .TOG_IDX(TOG_IDX),
      .TMO_IDX(TMO_IDX)
   ) u_tap (
      .data_i(rd_data),
      .tog_o (tog),
      .tmo_o (tmo)
   );

   tp_pair_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_first),
      .bit_i  (tog),
      .first_o(first_bit)
   );

   tp_poll_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .rd_valid_i  (rd_valid),
      .tog_i       (tog),
      .tmo_i       (tmo),
      .first_i     (first_bit),
      .load_first_o(load_first),
      .rd_req_o    (rd_req),
      .busy_o      (busy),
      .done_ok_o   (done_ok),
      .done_fail_o (done_fail)
   );

   assign rd_addr = STATUS_ADDR;

   AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && rd_req)); // R2
   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_ok && done_fail)); // R8
   AST_OK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok |=> !done_ok); // R8
   AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_fail |=> !done_fail); // R8
   AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok || done_fail) |-> !busy); // R8
   AST_RESULT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok || done_fail) |-> $past(rd_req && rd_valid)); // R4
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !rd_valid) |=> busy); // R9
endmodule

// File: tb/toggle_poll_ctrl_tb.sv
module toggle_poll_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        start = 1'b0;
   logic        req0, busy0, ok0, fail0, vld0 = 1'b0;
   logic        req1, busy1, ok1, fail1, vld1 = 1'b0;
   logic [7:0]  dat0 = 8'h00, dat1 = 8'h00;
   logic [15:0] addr0, addr1;

   int combo = 0, lat = 0;
   int idx0 = 0, idx1 = 0, w0 = 0, w1 = 0;
   int checks = 0, errors = 0;
   int cycles = 0;

   toggle_poll_ctrl #(.USE_SECTOR_BIT(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_req(req0), .rd_addr(addr0),
      .rd_valid(vld0), .rd_data(dat0), .busy(busy0), .done_ok(ok0), .done_fail(fail0));

   toggle_poll_ctrl #(.USE_SECTOR_BIT(1'b1)) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_req(req1), .rd_addr(addr1),
      .rd_valid(vld1), .rd_data(dat1), .busy(busy1), .done_ok(ok1), .done_fail(fail1));

   // Scripted status bytes: bit 6 = c[i], bit 2 = c[5-i], bit 5 = c[6+i]; beyond six reads all zero.
   function automatic logic [7:0] byte_at(int c, int i);
      logic [7:0] b;
      if (i >= 6) return 8'h00;
      b    = 8'((i * 37 + c * 11) & 8'h9B);
      b[6] = c[i];
      b[2] = c[5 - i];
      b[5] = c[6 + i];
      return b;
   endfunction

   task automatic ref_run(input int c, input int pos, output int n, output bit ok);
      int  i = 0;
      bit  fin = 0;
      logic [7:0] a, b;
      while (!fin) begin
         a = byte_at(c, i); b = byte_at(c, i + 1); i += 2;
         if (a[pos] == b[pos]) begin ok = 1; fin = 1; end
         else if (b[5]) begin
            a = byte_at(c, i); b = byte_at(c, i + 1); i += 2;
            ok = (a[pos] == b[pos]); fin = 1;
         end
      end
      n = i;
   endtask

   always @(negedge clk) begin
      if (start && !busy0) begin idx0 <= 0; w0 <= 0; vld0 <= 1'b0; end
      else if (vld0) vld0 <= 1'b0;
      else if (req0) begin
         if (w0 >= lat) begin vld0 <= 1'b1; dat0 <= byte_at(combo, idx0); idx0 <= idx0 + 1; w0 <= 0; end
         else begin w0 <= w0 + 1; dat0 <= ~byte_at(combo, idx0); end
      end
   end

   always @(negedge clk) begin
      if (start && !busy1) begin idx1 <= 0; w1 <= 0; vld1 <= 1'b0; end
      else if (vld1) vld1 <= 1'b0;
      else if (req1) begin
         if (w1 >= lat) begin vld1 <= 1'b1; dat1 <= byte_at(combo, idx1); idx1 <= idx1 + 1; w1 <= 0; end
         else begin w1 <= w1 + 1; dat1 <= ~byte_at(combo, idx1); end
      end
   end

   task automatic check(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s combo=%0d lat=%0d actual=%0d expected=%0d", req, combo, lat, act, exp);
      end
   endtask

   task automatic run_one(input int c, input int l, input bit poke);
      bit got0 = 0, got1 = 0, r0 = 0, r1 = 0, e0, e1;
      int n0 = 0, n1 = 0, x0, x1, cyc = 0;
      combo = c; lat = l;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      check(busy0 && req0 && busy1 && req1, "R2 busy/req after start", int'(busy0 & busy1), 1);
      check(addr0 == 16'h0000, "R2 address", int'(addr0), 0);
      ref_run(c, 6, x0, e0);
      ref_run(c, 2, x1, e1);
      while (!(got0 && got1) && cyc < 400) begin
         start = (poke && cyc == 0);
         @(posedge clk); #1;
         cyc++;
         if (!got0 && (ok0 || fail0)) begin
            got0 = 1; r0 = ok0; n0 = idx0;
            check(!busy0 && !(ok0 && fail0), "R8 result while idle", int'(busy0), 0);
         end
         if (!got1 && (ok1 || fail1)) begin
            got1 = 1; r1 = ok1; n1 = idx1;
            check(!busy1 && !(ok1 && fail1), "R8 result while idle (alt)", int'(busy1), 0);
         end
      end
      start = 1'b0;
      check(got0 && got1, "R8 result reported", int'(got0 & got1), 1);
      // R4 R5 R6 R7 R3 R9: outcome and read count on bit 6
      check(r0 == e0, e0 ? "R6 R4 success outcome" : "R7 failure outcome", int'(r0), int'(e0));
      check(n0 == x0, poke ? "R9 read count with extra start" : "R5 R3 read count", n0, x0);
      // R10: alternate instance uses bit 2
      check(r1 == e1, "R10 outcome on bit 2", int'(r1), int'(e1));
      check(n1 == x1, "R10 read count on bit 2", n1, x1);
      @(posedge clk); #1;
      check(!ok0 && !fail0 && !ok1 && !fail1, "R8 single-cycle pulse", int'(ok0 | fail0), 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 190000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      check(!busy0 && !req0 && !ok0 && !fail0, "R1 reset state", int'(busy0 | req0), 0);
      check(!busy1 && !req1 && !ok1 && !fail1, "R1 reset state (alt)", int'(busy1 | req1), 0);
      for (int c = 0; c < 4096; c++) begin
         run_one(c, c % 3, (c % 5) == 0);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule